// File: doc/BRIEF.md
# Bus configuration cycle initiator

This block lets a local processor run single-word configuration and I/O transactions on a PCI-style multiplexed bus. Software loads an address register and, for writes, a data register. It then writes a control word that holds the byte enables and the transfer direction. That control write starts the transaction at once. The block runs one address clock with the frame strobe asserted and then one data phase. It holds the data phase until the target signals ready or until a fixed wait limit runs out.

There are two register sets, one for configuration space and one for I/O space. Only one transaction can be in flight at a time. For configuration cycles, the upper address field is a one-hot selector that drives the per-device select lines during the address clock. Bits 10:8 carry the function number and pass through unchanged. Completion is reported through busy and done flags, and the done flags are cleared by writing ones. An interrupt request is raised while any done flag is set and the interrupt enable is on.

Register map (word offset on `cpu_addr`):
- 0: interrupt enable in bit 0.
- 1: status. Bit 0 is configuration busy, bit 1 is I/O busy, bit 2 is configuration done, bit 3 is I/O done, bit 4 is the refused-launch error and bit 5 is the wait-limit error. Bits 2 to 5 are cleared by writing 1; bits 0 and 1 are read-only.
- 2: configuration address.
- 3: configuration data.
- 4: configuration control, which also triggers a cycle.
- 5: I/O address.
- 6: I/O data.
- 7: I/O control, which also triggers a cycle.

The control offsets read as zero.

Top module: `buscyc_initiator`

## Requirements
- R1: After reset every register and status bit reads 0, `irq` is 0, and the bus is idle. Idle means `bus_frame_n`=1, `bus_irdy_n`=1, `bus_cbe_n`=4'b1111, `bus_ad_oe`=0, `bus_ad_out`=0 and `bus_idsel`=0.
- R2: A control write (offset 4 or 7) with neither busy flag set does two things on that clock. It sets the matching busy bit (status bit 0 or bit 1), and the next clock is the address phase. During the address phase `bus_frame_n`=0 and `bus_ad_oe`=1. `bus_cbe_n` carries the command: 1010 for configuration read, 1011 for configuration write, 0010 for I/O read and 0011 for I/O write.
- R3: The address phase lasts exactly one clock. The data phase follows with `bus_frame_n`=1 and `bus_irdy_n`=0, and `bus_cbe_n` equals control bits 3:0, where 0 means the byte takes part and bit 0 is the least significant byte. The outputs stay unchanged until `bus_trdy_n` is sampled low.
- R4: Control bit 4 selects the direction: 1 is read and 0 is write. On a read, the data register of that space takes `bus_ad_in` on the clock where ready is sampled, and `bus_ad_oe`=0 during the data phase. On a write, `bus_ad_out` carries the data register with `bus_ad_oe`=1, and the data register is left unchanged.
- R5: On the clock that ends the data phase, the busy bit clears and the done bit of that space (status bit 2 or bit 3) sets. The bus then returns to idle.
- R6: Writing 1 to status bits 2 to 5 clears them. Writing 0 leaves them as they are. A completion on the same clock takes priority over the clear.
- R7: `irq` = interrupt enable AND (configuration done OR I/O done).
- R8: A control write while either busy bit is set is refused. No bus cycle starts, neither busy bit changes, and sticky status bit 4 sets.
- R9: When ready has not been seen after 16 data-phase clocks, the cycle ends anyway. Done and status bit 5 set, and a read leaves the data register unchanged.
- R10: In a configuration address phase, `bus_ad_out` is the address register with bits 1:0 forced to 00, and `bus_idsel` equals address bits 31:11. In an I/O address phase, `bus_ad_out` is the address register unchanged and `bus_idsel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register word offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` |
| irq | output | 1 | Interrupt request |
| bus_ad_out | output | 32 | Multiplexed address/data driven onto the bus |
| bus_ad_oe | output | 1 | Output enable for `bus_ad_out` |
| bus_ad_in | input | 32 | Data returned by the target |
| bus_cbe_n | output | 4 | Command in the address phase, active-low byte enables in the data phase |
| bus_frame_n | output | 1 | Transaction frame strobe, active low |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_idsel | output | 21 | Per-device select lines, valid in the configuration address phase |

## Verification
The assertions assume a well-behaved environment. The configuration address's device field is one-hot or zero when a cycle is launched. `bus_trdy_n` matters only while the data phase is open. `cpu_addr` is stable whenever `cpu_wr` is high. The stimulus always loads single-bit device fields and drives ready low only in the data-phase clock chosen by a per-transaction delay, keeping it high otherwise. It also writes registers only through single-clock strobes with the offset held for that clock.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam logic [REG_AW-1:0] OFS_IEN      = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT     = 3'd1;
    localparam logic [REG_AW-1:0] OFS_CFG_ADDR = 3'd2;
    localparam logic [REG_AW-1:0] OFS_CFG_DATA = 3'd3;
    localparam logic [REG_AW-1:0] OFS_CFG_CTL  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_IO_ADDR  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_IO_DATA  = 3'd6;
    localparam logic [REG_AW-1:0] OFS_IO_CTL   = 3'd7;

    localparam int ST_CFG_BUSY = 0;
    localparam int ST_IO_BUSY  = 1;
    localparam int ST_CFG_DONE = 2;
    localparam int ST_IO_DONE  = 3;
    localparam int ST_COLL     = 4;
    localparam int ST_TMO      = 5;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;

endpackage

// File: rtl/buscyc_regs.sv
module buscyc_regs
    import buscyc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [REG_AW-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                irq,
    output logic                launch,
    output logic                launch_io,
    output logic [DATA_W-1:0]   launch_addr,
    output logic [DATA_W-1:0]   launch_data,
    input  logic                cmpl_valid,
    input  logic                cmpl_tmo,
    input  logic                cmpl_rd,
    input  logic [DATA_W-1:0]   cmpl_rdata
);

    localparam int ST_W = ST_TMO + 1;

    typedef struct packed {
        logic              ien;
        logic [DATA_W-1:0] cfg_addr;
        logic [DATA_W-1:0] cfg_data;
        logic [DATA_W-1:0] io_addr;
        logic [DATA_W-1:0] io_data;
        logic              cfg_busy;
        logic              io_busy;
        logic              cfg_done;
        logic              io_done;
        logic              coll;
        logic              tmo;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  any_busy;
    logic [ST_W-1:0] stat_word;

    always_comb begin
        regs_d    = regs_q;
        launch    = 1'b0;
        launch_io = 1'b0;
        any_busy  = regs_q.cfg_busy | regs_q.io_busy;

        if (cpu_wr) begin
            case (cpu_addr)
                OFS_IEN:      regs_d.ien = cpu_wdata[0];
                OFS_STAT: begin
                    if (cpu_wdata[ST_CFG_DONE]) regs_d.cfg_done = 1'b0;
                    if (cpu_wdata[ST_IO_DONE])  regs_d.io_done  = 1'b0;
                    if (cpu_wdata[ST_COLL])     regs_d.coll     = 1'b0;
                    if (cpu_wdata[ST_TMO])      regs_d.tmo      = 1'b0;
                end
                OFS_CFG_ADDR: regs_d.cfg_addr = cpu_wdata;
                OFS_CFG_DATA: regs_d.cfg_data = cpu_wdata;
                OFS_IO_ADDR:  regs_d.io_addr  = cpu_wdata;
                OFS_IO_DATA:  regs_d.io_data  = cpu_wdata;
                OFS_CFG_CTL, OFS_IO_CTL: begin
                    if (any_busy) begin
                        regs_d.coll = 1'b1;
                    end else begin
                        launch    = 1'b1;
                        launch_io = (cpu_addr == OFS_IO_CTL);
                        if (launch_io) regs_d.io_busy  = 1'b1;
                        else           regs_d.cfg_busy = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // completion is applied last so it wins over a same-clock clear or data write
        if (cmpl_valid) begin
            if (regs_q.io_busy) begin
                regs_d.io_busy = 1'b0;
                regs_d.io_done = 1'b1;
                if (cmpl_rd && !cmpl_tmo) regs_d.io_data = cmpl_rdata;
            end else begin
                regs_d.cfg_busy = 1'b0;
                regs_d.cfg_done = 1'b1;
                if (cmpl_rd && !cmpl_tmo) regs_d.cfg_data = cmpl_rdata;
            end
            if (cmpl_tmo) regs_d.tmo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign launch_addr = launch_io ? regs_q.io_addr : regs_q.cfg_addr;
    assign launch_data = launch_io ? regs_q.io_data : regs_q.cfg_data;

    assign stat_word = {regs_q.tmo, regs_q.coll, regs_q.io_done,
                        regs_q.cfg_done, regs_q.io_busy, regs_q.cfg_busy};

    always_comb begin
        case (cpu_addr)
            OFS_IEN:      cpu_rdata = {{(DATA_W-1){1'b0}}, regs_q.ien};
            OFS_STAT:     cpu_rdata = {{(DATA_W-ST_W){1'b0}}, stat_word};
            OFS_CFG_ADDR: cpu_rdata = regs_q.cfg_addr;
            OFS_CFG_DATA: cpu_rdata = regs_q.cfg_data;
            OFS_IO_ADDR:  cpu_rdata = regs_q.io_addr;
            OFS_IO_DATA:  cpu_rdata = regs_q.io_data;
            default:      cpu_rdata = '0;
        endcase
    end

    assign irq = regs_q.ien & (regs_q.cfg_done | regs_q.io_done);

    // R8: the two spaces never hold a transaction at the same time
    p_one_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(regs_q.cfg_busy && regs_q.io_busy));

    // R8: a trigger while busy leaves the error flag set
    p_refuse_sets_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr == OFS_CFG_CTL || cpu_addr == OFS_IO_CTL) && any_busy)
        |=> regs_q.coll);

    // R2: an accepted trigger is visible as busy on the next clock
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (regs_q.cfg_busy || regs_q.io_busy));

    // R5: a completion always leaves a done flag and no busy flag
    p_cmpl_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> ((regs_q.cfg_done || regs_q.io_done)
                        && !regs_q.cfg_busy && !regs_q.io_busy));

    // R6: a write-one clear without a racing completion removes the flag
    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == OFS_STAT && cpu_wdata[ST_CFG_DONE] && !cmpl_valid)
        |=> !regs_q.cfg_done);

endmodule

// File: rtl/buscyc_seq.sv
module buscyc_seq
    import buscyc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEV_N   = 21,
    parameter int TMO_CYC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                launch_io,
    input  logic [DATA_W-1:0]   launch_addr,
    input  logic [DATA_W-1:0]   launch_data,
    input  logic [DATA_W/8:0]   launch_ctl,
    output logic                cmpl_valid,
    output logic                cmpl_tmo,
    output logic                cmpl_rd,
    output logic [DATA_W-1:0]   cmpl_rdata,
    output logic [DATA_W-1:0]   bus_ad_out,
    output logic                bus_ad_oe,
    input  logic [DATA_W-1:0]   bus_ad_in,
    output logic [DATA_W/8-1:0] bus_cbe_n,
    output logic                bus_frame_n,
    output logic                bus_irdy_n,
    input  logic                bus_trdy_n,
    output logic [DEV_N-1:0]    bus_idsel
);

    localparam int BE_W  = DATA_W / 8;
    localparam int RD_B  = BE_W;
    localparam int CNT_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(TMO_CYC - 1);

    typedef struct packed {
        phase_e            phase;
        logic              is_io;
        logic              is_rd;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
        logic [CNT_W-1:0]  wcnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [3:0] cmd;

    always_comb begin
        seq_d      = seq_q;
        cmpl_valid = 1'b0;
        cmpl_tmo   = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (launch) begin
                    seq_d.phase = PH_ADDR;
                    seq_d.is_io = launch_io;
                    seq_d.is_rd = launch_ctl[RD_B];
                    seq_d.be    = launch_ctl[BE_W-1:0];
                    seq_d.addr  = launch_addr;
                    seq_d.data  = launch_data;
                end
            end
            PH_ADDR: begin
                seq_d.phase = PH_DATA;
                seq_d.wcnt  = '0;
            end
            PH_DATA: begin
                if (!bus_trdy_n) begin
                    cmpl_valid  = 1'b1;
                    seq_d.phase = PH_IDLE;
                end else if (seq_q.wcnt == LAST_W) begin
                    cmpl_valid  = 1'b1;
                    cmpl_tmo    = 1'b1;
                    seq_d.phase = PH_IDLE;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign cmpl_rd    = seq_q.is_rd;
    assign cmpl_rdata = bus_ad_in;

    always_comb begin
        case ({seq_q.is_io, seq_q.is_rd})
            2'b01:   cmd = CMD_CFG_RD;
            2'b00:   cmd = CMD_CFG_WR;
            2'b11:   cmd = CMD_IO_RD;
            default: cmd = CMD_IO_WR;
        endcase
    end

    always_comb begin
        bus_frame_n = 1'b1;
        bus_irdy_n  = 1'b1;
        bus_cbe_n   = '1;
        bus_ad_out  = '0;
        bus_ad_oe   = 1'b0;
        bus_idsel   = '0;
        case (seq_q.phase)
            PH_ADDR: begin
                bus_frame_n = 1'b0;
                bus_ad_oe   = 1'b1;
                bus_cbe_n   = BE_W'(cmd);
                if (seq_q.is_io) begin
                    bus_ad_out = seq_q.addr;
                end else begin
                    bus_ad_out = {seq_q.addr[DATA_W-1:2], 2'b00};
                    bus_idsel  = seq_q.addr[DATA_W-1 -: DEV_N];
                end
            end
            PH_DATA: begin
                bus_irdy_n = 1'b0;
                bus_cbe_n  = seq_q.be;
                bus_ad_oe  = !seq_q.is_rd;
                bus_ad_out = seq_q.is_rd ? '0 : seq_q.data;
            end
            default: ;
        endcase
    end

    // R3: the frame strobe lasts one clock and is followed by the data phase
    p_frame_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_frame_n |=> (bus_frame_n && !bus_irdy_n));

    // R10: device selects are only driven inside the address clock
    p_idsel_addr_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_idsel) |-> !bus_frame_n);

    // R3: while the target is not ready and the limit is not hit, the data phase holds
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_irdy_n && bus_trdy_n && !cmpl_tmo)
        |=> (!bus_irdy_n && $stable(bus_cbe_n) && $stable(bus_ad_out)));

    // R5: after completion the bus is released
    p_cmpl_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> (bus_irdy_n && bus_frame_n && !bus_ad_oe));

    // R9: the wait limit only ends a data phase whose target stayed not ready
    p_tmo_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_tmo |-> (bus_trdy_n && !bus_irdy_n));

endmodule

// File: rtl/buscyc_initiator.sv
module buscyc_initiator
    import buscyc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEV_LSB = 11,
    parameter int TMO_CYC = 16,
    localparam int BE_W   = DATA_W / 8,
    localparam int DEV_N  = DATA_W - DEV_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [BE_W-1:0]   bus_cbe_n,
    output logic              bus_frame_n,
    output logic              bus_irdy_n,
    input  logic              bus_trdy_n,
    output logic [DEV_N-1:0]  bus_idsel
);

    logic              launch;
    logic              launch_io;
    logic [DATA_W-1:0] launch_addr;
    logic [DATA_W-1:0] launch_data;
    logic              cmpl_valid;
    logic              cmpl_tmo;
    logic              cmpl_rd;
    logic [DATA_W-1:0] cmpl_rdata;

    buscyc_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .irq         (irq),
        .launch      (launch),
        .launch_io   (launch_io),
        .launch_addr (launch_addr),
        .launch_data (launch_data),
        .cmpl_valid  (cmpl_valid),
        .cmpl_tmo    (cmpl_tmo),
        .cmpl_rd     (cmpl_rd),
        .cmpl_rdata  (cmpl_rdata)
    );

    buscyc_seq #(
        .DATA_W  (DATA_W),
        .DEV_N   (DEV_N),
        .TMO_CYC (TMO_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_io   (launch_io),
        .launch_addr (launch_addr),
        .launch_data (launch_data),
        .launch_ctl  (cpu_wdata[BE_W:0]),
        .cmpl_valid  (cmpl_valid),
        .cmpl_tmo    (cmpl_tmo),
        .cmpl_rd     (cmpl_rd),
        .cmpl_rdata  (cmpl_rdata),
        .bus_ad_out  (bus_ad_out),
        .bus_ad_oe   (bus_ad_oe),
        .bus_ad_in   (bus_ad_in),
        .bus_cbe_n   (bus_cbe_n),
        .bus_frame_n (bus_frame_n),
        .bus_irdy_n  (bus_irdy_n),
        .bus_trdy_n  (bus_trdy_n),
        .bus_idsel   (bus_idsel)
    );

endmodule

// File: tb/buscyc_initiator_bench.sv
`timescale 1ns/1ps
module buscyc_initiator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_addr = 3'd0;
    logic [31:0] cpu_wdata = 32'd0;
    logic [31:0] cpu_rdata;
    logic        irq;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [31:0] bus_ad_in = 32'd0;
    logic [3:0]  bus_cbe_n;
    logic        bus_frame_n;
    logic        bus_irdy_n;
    logic        bus_trdy_n = 1'b1;
    logic [20:0] bus_idsel;

    always #2 clk = ~clk;

    buscyc_initiator u_buscyc_initiator (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_cbe_n(bus_cbe_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
        .bus_trdy_n(bus_trdy_n), .bus_idsel(bus_idsel)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          resp_delay = 0;
    logic [31:0] resp_data = 32'd0;
    int          m_phase = 0;
    int          m_wait = 0;
    logic        m_ien = 0;
    logic [31:0] m_cfg_addr = 0, m_cfg_data = 0, m_io_addr = 0, m_io_data = 0;
    logic        m_cfg_busy = 0, m_io_busy = 0, m_cfg_done = 0, m_io_done = 0;
    logic        m_coll = 0, m_tmo = 0;
    logic        m_cur_io = 0, m_cur_rd = 0;
    logic [3:0]  m_cur_be = 0;
    logic [31:0] m_cur_addr = 0, m_cur_data = 0;
    logic        t_fin, t_tmo, t_busy;
    int          t_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_wait = 0; m_ien = 0;
            m_cfg_addr = 0; m_cfg_data = 0; m_io_addr = 0; m_io_data = 0;
            m_cfg_busy = 0; m_io_busy = 0; m_cfg_done = 0; m_io_done = 0;
            m_coll = 0; m_tmo = 0;
        end else begin
            t_busy = m_cfg_busy || m_io_busy;
            t_fin = 0; t_tmo = 0; t_next = m_phase;
            if (m_phase == 2) begin
                if (!bus_trdy_n) t_fin = 1;
                else if (m_wait == 15) begin t_fin = 1; t_tmo = 1; end
                else m_wait++;
            end
            if (m_phase == 1) begin t_next = 2; m_wait = 0; end
            if (cpu_wr) begin
                case (cpu_addr)
                    3'd0: m_ien = cpu_wdata[0];
                    3'd1: begin
                        if (cpu_wdata[2]) m_cfg_done = 0;
                        if (cpu_wdata[3]) m_io_done = 0;
                        if (cpu_wdata[4]) m_coll = 0;
                        if (cpu_wdata[5]) m_tmo = 0;
                    end
                    3'd2: m_cfg_addr = cpu_wdata;
                    3'd3: m_cfg_data = cpu_wdata;
                    3'd5: m_io_addr = cpu_wdata;
                    3'd6: m_io_data = cpu_wdata;
                    default: begin
                        if (t_busy) m_coll = 1;
                        else begin
                            m_cur_io = (cpu_addr == 3'd7);
                            m_cur_rd = cpu_wdata[4];
                            m_cur_be = cpu_wdata[3:0];
                            m_cur_addr = m_cur_io ? m_io_addr : m_cfg_addr;
                            m_cur_data = m_cur_io ? m_io_data : m_cfg_data;
                            if (m_cur_io) m_io_busy = 1; else m_cfg_busy = 1;
                            t_next = 1;
                        end
                    end
                endcase
            end
            if (t_fin) begin
                t_next = 0;
                if (m_cur_io) begin
                    m_io_busy = 0; m_io_done = 1;
                    if (m_cur_rd && !t_tmo) m_io_data = bus_ad_in;
                end else begin
                    m_cfg_busy = 0; m_cfg_done = 1;
                    if (m_cur_rd && !t_tmo) m_cfg_data = bus_ad_in;
                end
                if (t_tmo) m_tmo = 1;
            end
            m_phase = t_next;
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_ien};
            3'd1: return {26'd0, m_tmo, m_coll, m_io_done, m_cfg_done, m_io_busy, m_cfg_busy};
            3'd2: return m_cfg_addr;
            3'd3: return m_cfg_data;
            3'd5: return m_io_addr;
            3'd6: return m_io_data;
            default: return 32'd0;
        endcase
    endfunction

    // per-clock comparison, sampled mid-cycle
    int          frames = 0;
    int          irdy_cycles = 0;
    logic [31:0] snap_ad = 0, snap_wd = 0;
    logic [3:0]  snap_cmd = 0, snap_be = 0;
    logic [20:0] snap_idsel = 0;
    logic        snap_oe = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 register readback", cpu_rdata, exp_rdata(cpu_addr));
            chk("R7 irq", {31'd0, irq}, {31'd0, m_ien & (m_cfg_done | m_io_done)});
            if (m_phase == 1) begin
                chk("R2 frame", {31'd0, bus_frame_n}, 32'd0);
                chk("R2 command", {28'd0, bus_cbe_n},
                    {28'd0, m_cur_io ? (m_cur_rd ? 4'b0010 : 4'b0011)
                                     : (m_cur_rd ? 4'b1010 : 4'b1011)});
                chk("R10 address", bus_ad_out,
                    m_cur_io ? m_cur_addr : {m_cur_addr[31:2], 2'b00});
                chk("R10 idsel", {11'd0, bus_idsel}, m_cur_io ? 32'd0 : {11'd0, m_cur_addr[31:11]});
                chk("R2 oe", {31'd0, bus_ad_oe}, 32'd1);
            end else if (m_phase == 2) begin
                chk("R3 frame/irdy", {30'd0, bus_frame_n, bus_irdy_n}, 32'd2);
                chk("R3 byte enables", {28'd0, bus_cbe_n}, {28'd0, m_cur_be});
                chk("R4 oe", {31'd0, bus_ad_oe}, {31'd0, !m_cur_rd});
                chk("R4 write data", bus_ad_out, m_cur_rd ? 32'd0 : m_cur_data);
            end else begin
                chk("R5 idle bus", {bus_ad_out[26:0], bus_frame_n, bus_irdy_n, bus_ad_oe, |bus_idsel, &bus_cbe_n},
                    {27'd0, 5'b11001});
            end
            if (!bus_frame_n) begin
                frames++; irdy_cycles = 0;
                snap_ad = bus_ad_out; snap_cmd = bus_cbe_n; snap_idsel = bus_idsel;
            end
            if (!bus_irdy_n) begin
                irdy_cycles++;
                snap_be = bus_cbe_n; snap_wd = bus_ad_out; snap_oe = bus_ad_oe;
            end
        end
    end

    // target model: ready after resp_delay wait clocks of the data phase
    always @(negedge clk) begin
        #1;
        bus_trdy_n = !(m_phase == 2 && m_wait == resp_delay);
        bus_ad_in = resp_data;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); #1;
        cpu_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        cpu_addr = a;
        #0.5;
        d = cpu_rdata;
    endtask

    task automatic idle_wait();
        int k = 0;
        do begin
            @(negedge clk); #1;
            cpu_addr = 3'(k);
            k++;
        end while ((m_phase != 0 || m_cfg_busy || m_io_busy) && k < 200);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int f0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1;

        // R1: reset state
        rd(3'd1, v); chk("R1 status after reset", v, 32'd0);
        rd(3'd2, v); chk("R1 cfg address after reset", v, 32'd0);
        chk("R1 bus idle after reset", {bus_frame_n, bus_irdy_n, bus_cbe_n, bus_ad_oe, irq}, 8'b11111100);

        wr(3'd0, 32'd1);

        // configuration write: device bit 5, function 3, low bits set
        wr(3'd2, 32'h0001_0313);
        wr(3'd3, 32'hA5A5_1234);
        resp_delay = 2;
        wr(3'd4, 32'h0000_0003);
        rd(3'd1, v); chk("R2 cfg busy after trigger", v, 32'h1);
        idle_wait();
        chk("R10 cfg address low bits cleared", snap_ad, 32'h0001_0310);
        chk("R10 idsel one-hot", {11'd0, snap_idsel}, 32'h20);
        chk("R2 cfg write command", {28'd0, snap_cmd}, 32'hB);
        chk("R3 byte enables", {28'd0, snap_be}, 32'h3);
        chk("R4 write data driven", snap_wd, 32'hA5A5_1234);
        chk("R3 data phase length", irdy_cycles, 3);
        rd(3'd1, v); chk("R5 cfg done", v, 32'h4);
        rd(3'd3, v); chk("R4 write leaves data", v, 32'hA5A5_1234);
        chk("R7 irq with done", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'd0);
        rd(3'd1, v); chk("R6 zero write keeps done", v, 32'h4);
        wr(3'd1, 32'h4);
        rd(3'd1, v); chk("R6 write-one clears done", v, 32'h0);
        chk("R7 irq drops", {31'd0, irq}, 32'd0);

        // configuration read, ready at once
        resp_delay = 0; resp_data = 32'hDEAD_BEEF;
        wr(3'd4, 32'h0000_0010);
        idle_wait();
        chk("R2 cfg read command", {28'd0, snap_cmd}, 32'hA);
        chk("R4 read oe low", {31'd0, snap_oe}, 32'd0);
        rd(3'd3, v); chk("R4 read data captured", v, 32'hDEAD_BEEF);
        wr(3'd1, 32'h4);

        // I/O write, one byte
        wr(3'd5, 32'h0000_1237);
        wr(3'd6, 32'h0BAD_F00D);
        resp_delay = 3;
        wr(3'd7, 32'h0000_000E);
        rd(3'd1, v); chk("R2 io busy", v, 32'h2);
        idle_wait();
        chk("R10 io address unchanged", snap_ad, 32'h0000_1237);
        chk("R10 io idsel zero", {11'd0, snap_idsel}, 32'd0);
        chk("R2 io write command", {28'd0, snap_cmd}, 32'h3);
        chk("R3 io byte enables", {28'd0, snap_be}, 32'hE);
        chk("R3 io data phase length", irdy_cycles, 4);
        rd(3'd1, v); chk("R5 io done", v, 32'h8);
        wr(3'd1, 32'h8);

        // I/O read
        resp_delay = 1; resp_data = 32'h1357_9BDF;
        wr(3'd7, 32'h0000_0010);
        idle_wait();
        chk("R2 io read command", {28'd0, snap_cmd}, 32'h2);
        rd(3'd6, v); chk("R4 io read captured", v, 32'h1357_9BDF);
        wr(3'd1, 32'h8);

        // refused launch while busy
        resp_delay = 6; resp_data = 32'h2468_ACE0;
        f0 = frames;
        wr(3'd7, 32'h0000_0010);
        wr(3'd4, 32'h0000_0010);
        rd(3'd1, v); chk("R8 refused trigger", v, 32'h12);
        idle_wait();
        chk("R8 single frame", frames - f0, 1);
        rd(3'd3, v); chk("R8 cfg data untouched", v, 32'hDEAD_BEEF);
        rd(3'd1, v); chk("R8 error sticky", v, 32'h18);
        wr(3'd1, 32'h18);
        rd(3'd1, v); chk("R6 clear error and done", v, 32'h0);

        // wait limit on a configuration read
        resp_delay = 99; resp_data = 32'h0F0F_0F0F;
        wr(3'd4, 32'h0000_0010);
        idle_wait();
        chk("R9 wait clocks", irdy_cycles, 16);
        rd(3'd1, v); chk("R9 timeout status", v, 32'h24);
        rd(3'd3, v); chk("R9 data unchanged", v, 32'hDEAD_BEEF);
        wr(3'd0, 32'd0);
        rd(3'd1, v);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h24);
        rd(3'd1, v); chk("R6 clear timeout", v, 32'h0);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule